// File: doc/BRIEF.md
# Prescaled Timer Counter Core

This block is the counting heart of a general-purpose timer. A programmable divider thins out an incoming tick-enable stream. Each divided tick advances an up-counter. The counter runs over its full range in free-running mode. In restart mode, a match event from the first output-compare channel sends it back to zero. The wrap from the all-ones value to zero raises a sticky flag. Software clears that flag by writing a one, and the flag can also drive an interrupt line.

The surrounding timer owns the clock-source selection, the register interface and the compare and capture channels. It hands this core decoded control levels and single-cycle write strobes, and it reads the count back. A held software reset forces the whole core to its reset state. When the timer is switched off, the core either freezes the count or zeroes it, depending on the disable-policy input.

Top module: `prescaled_timer_core`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a rising edge), `count` is 0, `ovf_flag` is 0 and `ovf_irq` is 0.
- R2: While `tmr_en` is 0 and `clr_on_dis` is 0, `count` keeps its value no matter how `tick_en` behaves.
- R3: While `tmr_en` is 0 and `clr_on_dis` is 1, `count` is 0 from the next clock edge on, and ticks do not advance it.
- R4: With divider value P on `psc_val`, the count advances once per P+1 cycles in which `tick_en` is 1. P=0 advances on every tick and P=0xFFF advances on every 4096th tick.
- R5: In a cycle where `tick_en` is 0, neither the count nor the divider moves.
- R6: With `free_run` equal to 1, a counted tick at the all-ones count gives 0, and counting then carries on. `cmp1_hit` has no effect in this mode.
- R7: With `free_run` equal to 0, a `cmp1_hit` pulse makes the first counted tick at or after it load 0 instead of incrementing. A tick in the same cycle counts. Later ticks increment again. A restart at the all-ones value is not a wrap.
- R8: `ovf_flag` becomes 1 on the edge after a wrap in either mode. It stays 1 until a cycle with `ovf_clr` equal to 1, and `ovf_clr` equal to 0 leaves it alone. When a wrap and a clear fall in the same cycle, the flag ends at 1.
- R9: `ovf_irq` is 1 exactly when `ovf_flag` is 1 and `ovf_ie` is 1.
- R10: While `soft_rst` is 1, `count`, `ovf_flag` and the divider are held at 0, even with the timer enabled and ticking.
- R11: A cycle with `psc_wr` equal to 1 clears the divider and counts no tick. The next advance therefore needs P+1 fresh ticks.
- R12: Disabling the timer clears the divider. After re-enabling, the next advance needs P+1 fresh ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Held software reset, active high |
| tmr_en | input | 1 | Timer enable level |
| clr_on_dis | input | 1 | Disable policy: 1 zeroes the count while disabled, 0 keeps it |
| free_run | input | 1 | 1 selects free-running mode, 0 selects restart mode |
| tick_en | input | 1 | Timer clock tick enable, one cycle per source tick |
| psc_val | input | PSC_W (12) | Divider value P; the division ratio is P+1 |
| psc_wr | input | 1 | Strobe: the divider value has just been written |
| cmp1_hit | input | 1 | Single-cycle match event from compare channel 1 |
| ovf_ie | input | 1 | Rollover interrupt enable |
| ovf_clr | input | 1 | Write-one-to-clear strobe for the rollover flag |
| count | output | CNT_W (32) | Current counter value |
| ovf_flag | output | 1 | Sticky rollover flag |
| ovf_irq | output | 1 | Rollover interrupt request |

## Verification
Two pairs of events can land in the same cycle. A wrap can meet a flag clear, and a compare-match restart can meet the tick that applies it. The bench drives the counter to its all-ones value with the flag already set, then raises a tick and `ovf_clr` together. It judges the result by the count reaching zero while the flag reads 1. For the restart, it raises `cmp1_hit` together with a tick and expects 0 at once. It also raises the pulse without a tick, to confirm that the restart waits for the next tick and then applies only once.

// File: rtl/timer_core_pkg.sv
// Package: shared widths and the mode type of the prescaled timer core.
// Assumes: consumers take widths from here as defaults only.
package timer_core_pkg;
    localparam int unsigned DEF_CNT_W = 32;
    localparam int unsigned DEF_PSC_W = 12;

    // Counting policy picked by the free-run input
    typedef enum logic {
        MODE_RESTART  = 1'b0,
        MODE_FREE_RUN = 1'b1
    } count_mode_e;
endpackage

// File: rtl/tmr_prescaler.sv
// Module: tmr_prescaler
// Divides the tick-enable stream by psc_val+1 and issues one step per
// division period. Assumes psc_wr accompanies any change of psc_val.
// The divider restarts from zero on reset, soft reset, disable or write.
module tmr_prescaler #(
    parameter int unsigned PSC_W = timer_core_pkg::DEF_PSC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             run,
    input  logic             tick_en,
    input  logic [PSC_W-1:0] psc_val,
    input  logic             psc_wr,
    output logic             step
);
    logic [PSC_W-1:0] div_q;
    logic             at_term;
    logic             hold_clear;

    // Terminal test; >= keeps the divider safe if the value shrinks
    assign at_term    = (div_q >= psc_val);
    assign hold_clear = soft_rst || !run || psc_wr;

    // One step per division period, suppressed while the divider is cleared
    assign step = tick_en && at_term && !hold_clear;

    // Divider count: clear on any restart condition, else advance per tick
    always_ff @(posedge clk) begin
        if (!rst_n || hold_clear) begin
            div_q <= '0;
        end else if (tick_en) begin
            div_q <= at_term ? '0 : div_q + 1'b1;
        end
    end

    // R5
    step_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (tick_en && run));

    // R11
    wr_blocks_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psc_wr |-> !step);

    // R12
    div_clear_on_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (div_q == '0));
endmodule

// File: rtl/tmr_counter.sv
// Module: tmr_counter
// Up-counter advanced by prescaler steps. In restart mode a compare-1
// match pulse arms a restart, and the first step at or after it loads
// zero. Reports a one-cycle wrap when an increment leaves all-ones.
// Assumes step is only high while the timer runs.
module tmr_counter #(
    parameter int unsigned CNT_W = timer_core_pkg::DEF_CNT_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       soft_rst,
    input  logic                       run,
    input  logic                       clr_on_dis,
    input  timer_core_pkg::count_mode_e mode,
    input  logic                       step,
    input  logic                       restart_pulse,
    output logic [CNT_W-1:0]           count,
    output logic                       wrap
);
    import timer_core_pkg::*;

    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;
    logic             restart_now;
    logic             at_max;

    assign at_max      = (cnt_q == {CNT_W{1'b1}});
    assign restart_now = (mode == MODE_RESTART) && (pend_q || restart_pulse);
    assign wrap        = step && at_max && !restart_now;
    assign count       = cnt_q;

    // Restart request held until the step that applies it
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst || !run || mode == MODE_FREE_RUN) begin
            pend_q <= 1'b0;
        end else if (step) begin
            pend_q <= 1'b0;
        end else if (restart_pulse) begin
            pend_q <= 1'b1;
        end
    end

    // Count register: reset, disable policy, restart or increment
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            cnt_q <= '0;
        end else if (!run) begin
            if (clr_on_dis) begin
                cnt_q <= '0;
            end
        end else if (step) begin
            cnt_q <= restart_now ? '0 : cnt_q + 1'b1;
        end
    end

    // R2
    hold_on_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr_on_dis && !soft_rst) |=> $stable(cnt_q));

    // R3
    zero_on_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && clr_on_dis) |=> (cnt_q == '0));

    // R10
    soft_rst_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (cnt_q == '0));

    // R6
    free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && at_max && mode == MODE_FREE_RUN) |=> (cnt_q == '0));

    // R7
    restart_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && restart_pulse && mode == MODE_RESTART) |=> (cnt_q == '0));

    // R7
    restart_not_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && restart_pulse && mode == MODE_RESTART) |-> !wrap);
endmodule

// File: rtl/tmr_rollover_flag.sv
// Module: tmr_rollover_flag
// Sticky rollover flag with write-one-to-clear and an interrupt gate.
// A set in the same cycle as a clear wins, so no wrap is lost.
// Assumes set_i is a one-cycle pulse.
module tmr_rollover_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    logic flag_q;

    // Flag register: set priority over the software clear
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    // Interrupt gate
    assign flag = flag_q;
    assign irq  = flag_q && irq_en;

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !soft_rst) |=> flag_q);

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i && !soft_rst) |=> flag_q);

    // R10
    soft_rst_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !flag_q);
endmodule

// File: rtl/prescaled_timer_core.sv
// Module: prescaled_timer_core (top)
// Ties the divider, the counter and the rollover flag together.
// Assumes control inputs are already decoded levels and the write
// strobes last one cycle.
module prescaled_timer_core #(
    parameter int unsigned CNT_W = timer_core_pkg::DEF_CNT_W,
    parameter int unsigned PSC_W = timer_core_pkg::DEF_PSC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             tmr_en,
    input  logic             clr_on_dis,
    input  logic             free_run,
    input  logic             tick_en,
    input  logic [PSC_W-1:0] psc_val,
    input  logic             psc_wr,
    input  logic             cmp1_hit,
    input  logic             ovf_ie,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] count,
    output logic             ovf_flag,
    output logic             ovf_irq
);
    import timer_core_pkg::*;

    logic        step;
    logic        wrap;
    count_mode_e mode;

    // Mode decode from the free-run level
    assign mode = free_run ? MODE_FREE_RUN : MODE_RESTART;

    tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .run      (tmr_en),
        .tick_en  (tick_en),
        .psc_val  (psc_val),
        .psc_wr   (psc_wr),
        .step     (step)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .soft_rst      (soft_rst),
        .run           (tmr_en),
        .clr_on_dis    (clr_on_dis),
        .mode          (mode),
        .step          (step),
        .restart_pulse (cmp1_hit),
        .count         (count),
        .wrap          (wrap)
    );

    tmr_rollover_flag u_ovf (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .set_i    (wrap),
        .clr_i    (ovf_clr),
        .irq_en   (ovf_ie),
        .flag     (ovf_flag),
        .irq      (ovf_irq)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && !ovf_flag && !ovf_irq));

    // R5
    no_tick_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && tmr_en && !soft_rst) |=> $stable(count));
endmodule

// File: tb/prescaled_timer_core_tb.sv
`timescale 1ns/1ps
module prescaled_timer_core_tb;
    localparam int CW = 8;
    localparam int PW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 0, tmr_en = 0, clr_on_dis = 0, free_run = 1;
    logic tick_en = 0, psc_wr = 0, cmp1_hit = 0, ovf_ie = 0, ovf_clr = 0;
    logic [PW-1:0] psc_val = '0;
    logic [CW-1:0] count;
    logic ovf_flag, ovf_irq;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    prescaled_timer_core #(.CNT_W(CW), .PSC_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tmr_en(tmr_en),
        .clr_on_dis(clr_on_dis), .free_run(free_run), .tick_en(tick_en),
        .psc_val(psc_val), .psc_wr(psc_wr), .cmp1_hit(cmp1_hit),
        .ovf_ie(ovf_ie), .ovf_clr(ovf_clr), .count(count),
        .ovf_flag(ovf_flag), .ovf_irq(ovf_irq)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // n consecutive tick cycles, then the tick is lowered
    task automatic ticks(int n);
        @(negedge clk) tick_en = 1;
        repeat (n) @(negedge clk);
        tick_en = 0;
    endtask

    task automatic write_psc(int p);
        @(negedge clk) psc_val = PW'(p); psc_wr = 1;
        @(negedge clk) psc_wr = 0;
    endtask

    task automatic pulse_soft;
        @(negedge clk) soft_rst = 1;
        @(negedge clk) soft_rst = 0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 count", count, 0);
        chk("R1 flag", ovf_flag, 0);
        chk("R1 irq", ovf_irq, 0);
    endtask

    task automatic t_basic;
        tmr_en = 1;
        ticks(10);
        chk("R4 div1", count, 10);
        repeat (5) @(negedge clk);
        chk("R5 no tick", count, 10);
    endtask

    task automatic t_hold;
        @(negedge clk) tmr_en = 0; clr_on_dis = 0;
        ticks(5);
        chk("R2 hold", count, 10);
        @(negedge clk) tmr_en = 1;
    endtask

    task automatic t_prescale;
        write_psc(2);
        ticks(7);
        chk("R4 div3", count, 12);
        write_psc(12'hFFF);
        ticks(4095);
        chk("R4 div4096 early", count, 12);
        ticks(1);
        chk("R4 div4096", count, 13);
    endtask

    task automatic t_psc_wr;
        write_psc(3);
        ticks(2);
        write_psc(3);
        ticks(3);
        chk("R11 divider cleared", count, 13);
        ticks(1);
        chk("R11 step", count, 14);
    endtask

    task automatic t_dis_div;
        ticks(2);
        @(negedge clk) tmr_en = 0;
        @(negedge clk) tmr_en = 1;
        ticks(3);
        chk("R12 divider cleared", count, 14);
        ticks(1);
        chk("R12 step", count, 15);
    endtask

    task automatic t_clr_dis;
        @(negedge clk) tmr_en = 0; clr_on_dis = 1;
        @(negedge clk);
        chk("R3 zeroed", count, 0);
        ticks(3);
        chk("R3 stays zero", count, 0);
        @(negedge clk) tmr_en = 1; clr_on_dis = 0;
        write_psc(0);
    endtask

    task automatic t_soft;
        ticks(4);
        @(negedge clk) soft_rst = 1;
        ticks(4);
        chk("R10 count held", count, 0);
        @(negedge clk) soft_rst = 0;
        ticks(2);
        chk("R10 resumes", count, 2);
    endtask

    task automatic t_restart;
        pulse_soft();
        @(negedge clk) free_run = 0;
        ticks(6);
        chk("R7 before", count, 6);
        @(negedge clk) cmp1_hit = 1; tick_en = 1;
        @(negedge clk) cmp1_hit = 0; tick_en = 0;
        chk("R7 same cycle", count, 0);
        ticks(3);
        chk("R7 continues", count, 3);
        @(negedge clk) cmp1_hit = 1;
        @(negedge clk) cmp1_hit = 0;
        chk("R7 waits tick", count, 3);
        ticks(1);
        chk("R7 pending", count, 0);
        ticks(1);
        chk("R7 once", count, 1);
        @(negedge clk) free_run = 1; cmp1_hit = 1; tick_en = 1;
        @(negedge clk) cmp1_hit = 0; tick_en = 0;
        chk("R6 hit ignored", count, 2);
    endtask

    task automatic t_wrap;
        pulse_soft();
        ticks(255);
        chk("R6 at max", count, 255);
        chk("R8 not yet", ovf_flag, 0);
        ticks(1);
        chk("R6 wrap", count, 0);
        chk("R8 set", ovf_flag, 1);
        chk("R9 masked", ovf_irq, 0);
        @(negedge clk) ovf_ie = 1;
        @(negedge clk);
        chk("R9 irq", ovf_irq, 1);
        ticks(5);
        chk("R8 sticky", ovf_flag, 1);
        @(negedge clk) ovf_clr = 1;
        @(negedge clk) ovf_clr = 0;
        chk("R8 cleared", ovf_flag, 0);
        chk("R9 irq low", ovf_irq, 0);
        ticks(250);
        ticks(1);
        chk("R8 reset again", ovf_flag, 1);
        ticks(255);
        @(negedge clk) ovf_clr = 1; tick_en = 1;
        @(negedge clk) ovf_clr = 0; tick_en = 0;
        chk("R6 wrap2", count, 0);
        chk("R8 set wins", ovf_flag, 1);
        @(negedge clk) ovf_clr = 1;
        @(negedge clk) ovf_clr = 0;
        chk("R8 clear", ovf_flag, 0);
    endtask

    task automatic t_restart_wrap;
        @(negedge clk) free_run = 0;
        ticks(256);
        chk("R7 restart-mode wrap", count, 0);
        chk("R8 set in restart mode", ovf_flag, 1);
        pulse_soft();
        chk("R10 flag cleared", ovf_flag, 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_hold();
        t_prescale();
        t_psc_wr();
        t_dis_div();
        t_clr_dis();
        t_soft();
        t_restart();
        t_wrap();
        t_restart_wrap();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule